// File: doc/BRIEF.md
# Abort-Map Commit Resume Tracker

Each core of a transactional multiprocessor carries one of these units. When the core refuses a remote data request and so forces the requesting core's transaction to abort, the unit records that requester in a bitmap with one bit per core. At commit, a core whose bitmap is empty finishes at once. A core with at least one recorded victim sends one aggregated resume request toward its directory, and the full bitmap travels as the payload. Those victims then restart.

The unit also holds its own core frozen after that core's transaction is aborted by an opponent. The core does not retry. It stays frozen until some opponent's resume message reaches it. Bits are recorded only for conflicts found eagerly, at access time. A conflict found lazily can never recur against a live opponent, so it records nothing. The core count is a parameter, and the bitmap width follows it.

Top module: `abort_map_tracker`

## Requirements
- R1: After reset `stalled`, `rsm_valid` and `commit_done` are low and the bitmap is empty, so a first commit completes without a message.
- R2: A NACK event with `nack_eager` high sets bit `nack_core` of the bitmap. The bit index equals the core number. An event with `nack_eager` low, or with an index of `NUM_CORES` or above, sets nothing.
- R3: `commit_req` is a level held until `commit_done`. It is accepted when no message is pending, `commit_done` is low and the core is not stalled. If the bitmap is empty at acceptance, `commit_done` is high in the next cycle and no message is sent.
- R4: If the bitmap is non-empty at acceptance, `rsm_valid` rises in the next cycle and `rsm_map` carries every recorded bit. Exactly one message is sent for each commit.
- R5: While `rsm_valid` is high and `rsm_ready` is low, `rsm_valid` and `rsm_map` hold and `commit_done` stays low.
- R6: In the cycle after the handshake (`rsm_valid` and `rsm_ready` both high), `commit_done` is high for one cycle, `rsm_valid` is low and the sent bits are cleared from the bitmap.
- R7: A NACK event in the same cycle as commit acceptance is included in that commit's `rsm_map`.
- R8: A NACK event that arrives while a message is pending is not in that message. It stays recorded for the next commit.
- R9: `self_abort` makes `stalled` high in the next cycle. While the core is stalled, no commit is accepted.
- R10: `resume_in` while stalled clears `stalled` in the next cycle. `resume_in` while not stalled has no effect. When `self_abort` and `resume_in` occur in the same cycle, `self_abort` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nack_valid | input | 1 | This core refused a remote request this cycle |
| nack_eager | input | 1 | The conflict was found eagerly (at access time) |
| nack_core | input | IDX_W | Core number of the refused requester |
| self_abort | input | 1 | This core's own transaction was aborted by an opponent |
| resume_in | input | 1 | A resume message has arrived for this core |
| commit_req | input | 1 | Commit request, held until commit_done |
| rsm_ready | input | 1 | Directory accepts the resume request |
| rsm_valid | output | 1 | Resume request pending |
| rsm_map | output | NUM_CORES | Bitmap of cores to resume |
| commit_done | output | 1 | One-cycle pulse: commit finished |
| stalled | output | 1 | Core is frozen awaiting resume |

## Verification
The assertions check, on every cycle, the handshake rules: a pending message holds and is never empty, `commit_done` is a single pulse that follows the handshake, a stalled core never completes a commit, and the stall flag obeys its set, clear and ignore rules. Only the bench's scenarios show what the payload contains. That covers which NACKs land in which message, the rejection of lazy and out-of-range events, the same-cycle NACK at acceptance, and the carrying of a NACK that arrives during a wait into the next commit.

// File: rtl/amt_pkg.sv
package amt_pkg;
  typedef enum logic {
    CM_IDLE = 1'b0,
    CM_SEND = 1'b1
  } cm_state_e;
endpackage

// File: rtl/amt_nack_decode.sv
module amt_nack_decode #(
  parameter int NUM_CORES = 16,
  parameter int IDX_W     = 4
) (
  input  logic                 nack_valid,
  input  logic                 nack_eager,
  input  logic [IDX_W-1:0]     nack_core,
  output logic [NUM_CORES-1:0] set_vec
);
  logic hit_en;
  assign hit_en = nack_valid & nack_eager;

  // one comparator per core; indexes past the last core match nothing
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_dec
    assign set_vec[i] = hit_en & (nack_core == IDX_W'(i));
  end
endmodule

// File: rtl/amt_map_reg.sv
module amt_map_reg #(
  parameter int NUM_CORES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] set_vec,
  input  logic [NUM_CORES-1:0] clr_vec,
  output logic [NUM_CORES-1:0] live_map
);
  logic [NUM_CORES-1:0] map_q;

  // new NACKs are visible to the commit logic in the cycle they arrive
  assign live_map = map_q | set_vec;

  always_ff @(posedge clk) begin
    if (rst) map_q <= '0;
    else     map_q <= (map_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/amt_commit_ctrl.sv
module amt_commit_ctrl
  import amt_pkg::*;
#(
  parameter int NUM_CORES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 commit_req,
  input  logic                 stalled,
  input  logic [NUM_CORES-1:0] live_map,
  input  logic                 rsm_ready,
  output logic                 rsm_valid,
  output logic [NUM_CORES-1:0] rsm_map,
  output logic                 commit_done,
  output logic [NUM_CORES-1:0] clr_vec
);
  cm_state_e            state_q;
  logic [NUM_CORES-1:0] pay_q;
  logic                 done_q;
  logic                 accept;
  logic                 handshake;
  logic                 live_any;

  assign live_any  = |live_map;
  assign accept    = (state_q == CM_IDLE) & commit_req & ~done_q & ~stalled;
  assign handshake = (state_q == CM_SEND) & rsm_ready;
  assign clr_vec   = handshake ? pay_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CM_IDLE;
      pay_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        CM_IDLE: begin
          if (accept) begin
            if (live_any) begin
              pay_q   <= live_map;
              state_q <= CM_SEND;
            end else begin
              done_q  <= 1'b1;
            end
          end
        end
        CM_SEND: begin
          if (rsm_ready) begin
            state_q <= CM_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= CM_IDLE;
      endcase
    end
  end

  assign rsm_valid   = (state_q == CM_SEND);
  assign rsm_map     = pay_q;
  assign commit_done = done_q;
endmodule

// File: rtl/amt_stall_ctrl.sv
module amt_stall_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic self_abort,
  input  logic resume_in,
  output logic stalled
);
  logic stall_q;

  always_ff @(posedge clk) begin
    if (rst)             stall_q <= 1'b0;
    else if (self_abort) stall_q <= 1'b1;
    else if (resume_in)  stall_q <= 1'b0;
  end

  assign stalled = stall_q;
endmodule

// File: rtl/abort_map_tracker.sv
module abort_map_tracker #(
  parameter  int NUM_CORES = 16,
  localparam int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 nack_valid,
  input  logic                 nack_eager,
  input  logic [IDX_W-1:0]     nack_core,
  input  logic                 self_abort,
  input  logic                 resume_in,
  input  logic                 commit_req,
  input  logic                 rsm_ready,
  output logic                 rsm_valid,
  output logic [NUM_CORES-1:0] rsm_map,
  output logic                 commit_done,
  output logic                 stalled
);
  logic [NUM_CORES-1:0] set_vec;
  logic [NUM_CORES-1:0] clr_vec;
  logic [NUM_CORES-1:0] live_map;

  amt_nack_decode #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_dec (
    .nack_valid (nack_valid),
    .nack_eager (nack_eager),
    .nack_core  (nack_core),
    .set_vec    (set_vec)
  );

  amt_map_reg #(.NUM_CORES(NUM_CORES)) u_map (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .live_map (live_map)
  );

  amt_stall_ctrl u_stall (
    .clk        (clk),
    .rst        (rst),
    .self_abort (self_abort),
    .resume_in  (resume_in),
    .stalled    (stalled)
  );

  amt_commit_ctrl #(.NUM_CORES(NUM_CORES)) u_cmt (
    .clk         (clk),
    .rst         (rst),
    .commit_req  (commit_req),
    .stalled     (stalled),
    .live_map    (live_map),
    .rsm_ready   (rsm_ready),
    .rsm_valid   (rsm_valid),
    .rsm_map     (rsm_map),
    .commit_done (commit_done),
    .clr_vec     (clr_vec)
  );
endmodule

// File: rtl/amt_checker.sv
module amt_checker #(
  parameter int NUM_CORES = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 self_abort,
  input logic                 resume_in,
  input logic                 rsm_ready,
  input logic                 rsm_valid,
  input logic [NUM_CORES-1:0] rsm_map,
  input logic                 commit_done,
  input logic                 stalled
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!stalled && !rsm_valid && !commit_done));

  // R4
  payload_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    rsm_valid |-> (rsm_map != '0));

  // R5
  hold_while_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (rsm_valid && !rsm_ready) |=> (rsm_valid && $stable(rsm_map) && !commit_done));

  // R6
  done_after_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    (rsm_valid && rsm_ready) |=> (commit_done && !rsm_valid));

  // R3
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    commit_done |=> !commit_done);

  // R9
  abort_sets_stall_chk: assert property (@(posedge clk) disable iff (rst)
    self_abort |=> stalled);

  // R9
  no_commit_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (stalled && !rsm_valid) |=> !commit_done);

  // R10
  resume_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (stalled && resume_in && !self_abort) |=> !stalled);

  // R10
  stray_resume_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!stalled && !self_abort) |=> !stalled);
endmodule

bind abort_map_tracker amt_checker #(.NUM_CORES(NUM_CORES)) u_amt_chk (
  .clk         (clk),
  .rst         (rst),
  .self_abort  (self_abort),
  .resume_in   (resume_in),
  .rsm_ready   (rsm_ready),
  .rsm_valid   (rsm_valid),
  .rsm_map     (rsm_map),
  .commit_done (commit_done),
  .stalled     (stalled)
);

// File: tb/abort_map_tracker_test.sv
`timescale 1ns/1ps
module abort_map_tracker_test;
  localparam int N  = 12;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          nack_valid = 1'b0, nack_eager = 1'b0;
  logic [IW-1:0] nack_core = '0;
  logic          self_abort = 1'b0, resume_in = 1'b0, commit_req = 1'b0, rsm_ready = 1'b0;
  logic          rsm_valid, commit_done, stalled;
  logic [N-1:0]  rsm_map;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  abort_map_tracker #(.NUM_CORES(N)) uut (
    .clk(clk), .rst(rst), .nack_valid(nack_valid), .nack_eager(nack_eager),
    .nack_core(nack_core), .self_abort(self_abort), .resume_in(resume_in),
    .commit_req(commit_req), .rsm_ready(rsm_ready), .rsm_valid(rsm_valid),
    .rsm_map(rsm_map), .commit_done(commit_done), .stalled(stalled)
  );

  // behavioural reference: recorded victims as a set of core numbers
  bit m_rec [N];
  bit m_pay [N];
  bit m_valid, m_done, m_stall;

  function automatic logic [N-1:0] pack(input bit s [N]);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = s[i];
    return v;
  endfunction

  always @(posedge clk) begin
    int  newc;
    bit  any;
    bit  nd;
    newc = (nack_valid && nack_eager && int'(nack_core) < N) ? int'(nack_core) : -1;
    nd = 1'b0;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_rec[i] = 1'b0; m_pay[i] = 1'b0; end
      m_valid = 1'b0; m_done = 1'b0; m_stall = 1'b0;
    end else begin
      if (m_valid) begin
        if (rsm_ready) begin
          for (int i = 0; i < N; i++) if (m_pay[i]) m_rec[i] = 1'b0;
          m_valid = 1'b0;
          nd = 1'b1;
        end
        if (newc >= 0) m_rec[newc] = 1'b1;
      end else begin
        if (newc >= 0) m_rec[newc] = 1'b1;
        if (commit_req && !m_done && !m_stall) begin
          any = 1'b0;
          for (int i = 0; i < N; i++) any |= m_rec[i];
          if (any) begin
            for (int i = 0; i < N; i++) m_pay[i] = m_rec[i];
            m_valid = 1'b1;
          end else nd = 1'b1;
        end
      end
      m_done = nd;
      if (self_abort)     m_stall = 1'b1;
      else if (resume_in) m_stall = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // compare against the model at every falling edge, then return for driving
  task automatic cyc();
    @(negedge clk);
    cycles++;
    if (!rst) begin
      chk(rsm_valid === m_valid, "R4 rsm_valid per-cycle", 32'(rsm_valid), 32'(m_valid));
      chk(!m_valid || rsm_map === pack(m_pay), "R4 rsm_map per-cycle", 32'(rsm_map), 32'(pack(m_pay)));
      chk(commit_done === m_done, "R3 commit_done per-cycle", 32'(commit_done), 32'(m_done));
      chk(stalled === m_stall, "R9 stalled per-cycle", 32'(stalled), 32'(m_stall));
    end
  endtask

  task automatic nack(input int c, input bit eager);
    nack_valid = 1'b1; nack_eager = eager; nack_core = IW'(c);
    cyc();
    nack_valid = 1'b0; nack_eager = 1'b0;
  endtask

  initial begin
    logic [N-1:0] got;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk(!stalled && !rsm_valid && !commit_done, "R1 reset outputs", {29'd0, stalled, rsm_valid, commit_done}, 32'd0);

    // R1 R3: empty commit finishes next cycle without a message
    commit_req = 1'b1; rsm_ready = 1'b1;
    cyc();
    chk(commit_done === 1'b1, "R3 empty commit done", 32'(commit_done), 32'd1);
    chk(rsm_valid === 1'b0, "R1 no message after reset", 32'(rsm_valid), 32'd0);
    commit_req = 1'b0;
    cyc();

    // R2: eager victims 3 and 7; lazy 5 and out-of-range 13 ignored
    nack(3, 1'b1); nack(7, 1'b1); nack(5, 1'b0); nack(13, 1'b1);
    commit_req = 1'b1;
    cyc();
    chk(rsm_valid === 1'b1, "R4 message raised", 32'(rsm_valid), 32'd1);
    chk(rsm_map === 12'h088, "R2 payload bits", 32'(rsm_map), 32'h088);
    cyc();
    chk(commit_done === 1'b1 && rsm_valid === 1'b0, "R6 done after handshake", {30'd0, commit_done, rsm_valid}, 32'd2);
    commit_req = 1'b0;
    cyc();

    // R6: sent bits cleared, next commit empty
    commit_req = 1'b1;
    cyc();
    chk(commit_done === 1'b1 && rsm_valid === 1'b0, "R6 map cleared", {30'd0, commit_done, rsm_valid}, 32'd2);
    commit_req = 1'b0;
    cyc();

    // R7: NACK in the acceptance cycle is included
    commit_req = 1'b1; nack_valid = 1'b1; nack_eager = 1'b1; nack_core = IW'(1);
    rsm_ready = 1'b0;
    cyc();
    nack_valid = 1'b0;
    chk(rsm_map === 12'h002, "R7 same-cycle NACK in payload", 32'(rsm_map), 32'h002);

    // R5 R8: hold while blocked; NACK 9 during the wait
    nack(9, 1'b1);
    got = rsm_map;
    cyc(); cyc();
    chk(rsm_valid === 1'b1 && rsm_map === got, "R5 payload held", 32'(rsm_map), 32'(got));
    chk(commit_done === 1'b0, "R5 done withheld", 32'(commit_done), 32'd0);
    chk(rsm_map === 12'h002, "R8 late NACK not in payload", 32'(rsm_map), 32'h002);
    rsm_ready = 1'b1;
    cyc();
    chk(commit_done === 1'b1, "R6 done after late ready", 32'(commit_done), 32'd1);
    commit_req = 1'b0;
    cyc();
    commit_req = 1'b1;
    cyc();
    chk(rsm_map === 12'h200 && rsm_valid, "R8 late NACK in next commit", 32'(rsm_map), 32'h200);
    cyc();
    commit_req = 1'b0;
    cyc();

    // R9: abort stalls, commit refused while stalled
    self_abort = 1'b1;
    cyc();
    self_abort = 1'b0;
    chk(stalled === 1'b1, "R9 stall set", 32'(stalled), 32'd1);
    commit_req = 1'b1;
    cyc(); cyc(); cyc();
    chk(commit_done === 1'b0, "R9 no commit while stalled", 32'(commit_done), 32'd0);

    // R10: abort wins over same-cycle resume, then resume clears
    self_abort = 1'b1; resume_in = 1'b1;
    cyc();
    self_abort = 1'b0;
    chk(stalled === 1'b1, "R10 abort wins", 32'(stalled), 32'd1);
    cyc();
    resume_in = 1'b0;
    chk(stalled === 1'b0, "R10 resume clears", 32'(stalled), 32'd0);
    cyc();
    chk(commit_done === 1'b1, "R9 pending commit proceeds after resume", 32'(commit_done), 32'd1);
    commit_req = 1'b0;
    cyc();

    // R10: stray resume ignored
    resume_in = 1'b1;
    cyc();
    resume_in = 1'b0;
    cyc();
    chk(stalled === 1'b0, "R10 stray resume ignored", 32'(stalled), 32'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule